// File: doc/BRIEF.md
# Streaming coupled serial-concatenated convolutional encoder

This block turns a stream of K-bit information blocks into a stream of 3K-bit coded blocks, one coded block per accepted information block. Each block first passes through an outer recursive systematic convolutional encoder that yields K parity bits. The information and outer parity are then permuted together as one 2K-bit word. That permuted word is cut into M+1 equal slices. Slice 0 is used right away, and every other slice is held back for later blocks.

The inner encoder's 2K-bit input is built from slice 0 of the current block and from the slices that earlier blocks owe to this step. The result goes through a second permutation and then into an inner recursive encoder. Every second inner parity bit is kept, which gives an overall rate of 1/3. Neither trellis is ever terminated: each encoder starts a block in the state where it ended the previous one.

The block sits between a producer and a consumer. Both sides use a valid/ready handshake, and a whole block moves in one transfer. The output holds one coded block in a register, so a stalled consumer stalls the producer.

Top module: `coupled_concat_encoder`

## Requirements
- R1: A block is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever no coded block is held or the held one is taken in the same cycle. The coded block for an accepted input is on `out_data` with `out_valid` high from the next cycle. `out_valid` falls after a transfer that has no new acceptance.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged and `in_ready` is low.
- R3: `out_data[K-1:0]` equals the accepted information block.
- R4: The outer encoder works bit 0 first with state (s1, s2). Each step computes a = u^s1^s2 and parity p = a^s2, then updates s2<=s1 and s1<=a. The parity of bit i of the block is placed at `out_data[K+i]`.
- R5: The first permutation forms w with the information in bits 0..K-1 and the outer parity in bits K..2K-1. It outputs q[i] = w[(P1_MUL*i + P1_ADD) mod 2K].
- R6: q is cut into M+1 slices of S = 2K/(M+1) bits, with slice j = q[j*S +: S]. The inner input word x takes slot j (bits j*S +: S) from slice j of the block accepted j blocks earlier. Slot 0 comes from the current block.
- R7: The second permutation gives y[i] = x[(P2_MUL*i + P2_ADD) mod 2K]. The inner encoder runs the same recurrence as R4 over y, bit 0 first, and yields 2K parity bits.
- R8: Puncturing keeps the even-indexed inner parity bits: `out_data[2K+i]` = inner parity bit 2i, for i = 0..K-1.
- R9: Both trellis states carry over from one block to the next with no termination, and they change only when a block is accepted.
- R10: After reset, no coded block is held, both trellis states are zero, and any slice owed by a block that was never accepted reads as zero. An all-zero information block accepted right after reset therefore gives an all-zero coded block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Information block offered |
| in_ready | output | 1 | Block can be accepted this cycle |
| in_data | input | K | Information block, bit 0 encoded first |
| out_valid | output | 1 | Coded block held |
| out_ready | input | 1 | Consumer takes the coded block |
| out_data | output | 3K | Coded block: information, outer parity, punctured inner parity |

## Verification
A wrong trellis state or a stale slice does not stay hidden. A bad outer state corrupts the outer parity field of the very next coded block. A bad inner state, or a wrong delayed slice, corrupts the punctured inner field of that same block. Because the states never terminate, the error then keeps spreading into every later block. Delay storage that is cleared wrongly or shifted at the wrong time shows up one to M blocks later, in the inner field only. For this reason the bench compares each field separately against a reference model on every block, runs long chains of back-to-back blocks, and includes a reset in the middle of a stream and a stalled consumer.

// File: rtl/ccenc_pkg.sv
package ccenc_pkg;

  // Trellis state of a two-delay recursive encoder: s1 newest, s2 oldest.
  typedef struct packed {
    logic s2;
    logic s1;
  } trellis_t;

  // Source index of an affine permutation over n positions.
  function automatic int perm_idx(input int i, input int mul, input int add, input int n);
    return (mul * i + add) % n;
  endfunction

  // Feedback 1+D+D^2, feedforward 1+D^2.
  function automatic logic rsc_fb(input trellis_t s, input logic u);
    return u ^ s.s1 ^ s.s2;
  endfunction

  function automatic logic rsc_par(input trellis_t s, input logic u);
    return rsc_fb(s, u) ^ s.s2;
  endfunction

  function automatic trellis_t rsc_next(input trellis_t s, input logic u);
    trellis_t n;
    n.s1 = rsc_fb(s, u);
    n.s2 = s.s1;
    return n;
  endfunction

endpackage

// File: rtl/rsc_chain.sv
module rsc_chain
  import ccenc_pkg::*;
#(
  parameter int N = 16
) (
  input  trellis_t       st_i,
  input  logic [N-1:0]   bits_i,
  output logic [N-1:0]   par_o,
  output trellis_t       st_o
);

  // Whole block in one cycle: the trellis is unrolled over N bit steps.
  always_comb begin
    trellis_t s;
    s = st_i;
    for (int i = 0; i < N; i++) begin
      par_o[i] = rsc_par(s, bits_i[i]);
      s = rsc_next(s, bits_i[i]);
    end
    st_o = s;
  end

endmodule

// File: rtl/perm_net.sv
module perm_net
  import ccenc_pkg::*;
#(
  parameter int N   = 32,
  parameter int MUL = 5,
  parameter int ADD = 3
) (
  input  logic [N-1:0] d_i,
  output logic [N-1:0] d_o
);

  for (genvar i = 0; i < N; i++) begin : g_wire
    localparam int SRC = perm_idx(i, MUL, ADD, N);
    assign d_o[i] = d_i[SRC];
  end

endmodule

// File: rtl/slice_delay.sv
module slice_delay #(
  parameter int S = 16,
  parameter int M = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic [M*S-1:0] late_i,   // slices 1..M of the current block
  output logic [M*S-1:0] owed_o    // slot d-1: slice d of the block d steps back
);

  // Stage d keeps only slices d..M of the block d steps back (triangular store).
  function automatic int tri_off(input int d);
    int acc;
    acc = 0;
    for (int e = 1; e < d; e++) acc += (M + 1 - e) * S;
    return acc;
  endfunction

  localparam int TRI = tri_off(M + 1);

  logic [TRI-1:0] tri_q, tri_d;

  always_comb begin
    tri_d = tri_q;
    if (adv) begin
      for (int d = 1; d <= M; d++) begin
        for (int b = 0; b < (M + 1 - d) * S; b++) begin
          if (d == 1) tri_d[tri_off(d) + b] = late_i[b];
          else        tri_d[tri_off(d) + b] = tri_q[tri_off(d - 1) + S + b];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tri_q <= '0;
    else        tri_q <= tri_d;
  end

  for (genvar d = 1; d <= M; d++) begin : g_tap
    localparam int OFF = tri_off(d);
    assign owed_o[(d-1)*S +: S] = tri_q[OFF +: S];
  end

endmodule

// File: rtl/coupled_concat_encoder.sv
module coupled_concat_encoder
  import ccenc_pkg::*;
#(
  parameter int K      = 16,
  parameter int M      = 1,
  parameter int P1_MUL = 5,
  parameter int P1_ADD = 3,
  parameter int P2_MUL = 7,
  parameter int P2_ADD = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [K-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3*K-1:0]   out_data
);

  localparam int N  = 2 * K;
  localparam int S  = N / (M + 1);
  localparam int CW = 3 * K;

  if (M < 1 || (N % (M + 1)) != 0) begin : g_bad_cfg
    $error("coupled_concat_encoder: 2K must split into M+1 equal slices, M >= 1");
  end

  // Named events for the checker
  logic in_fire;
  logic out_fire;

  trellis_t outer_st, outer_nx;
  trellis_t inner_st, inner_nx;

  logic [K-1:0]   outer_par;
  logic [N-1:0]   mixed_w, perm1_w, inner_in, perm2_w, inner_par;
  logic [K-1:0]   punct;
  logic [M*S-1:0] owed;

  logic            out_valid_q;
  logic [CW-1:0]   out_data_q;

  assign in_ready = !out_valid_q || out_ready;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid_q && out_ready;

  rsc_chain #(.N(K)) u_outer (
    .st_i  (outer_st),
    .bits_i(in_data),
    .par_o (outer_par),
    .st_o  (outer_nx)
  );

  assign mixed_w = {outer_par, in_data};

  perm_net #(.N(N), .MUL(P1_MUL), .ADD(P1_ADD)) u_perm1 (
    .d_i(mixed_w),
    .d_o(perm1_w)
  );

  slice_delay #(.S(S), .M(M)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (in_fire),
    .late_i(perm1_w[N-1:S]),
    .owed_o(owed)
  );

  assign inner_in = {owed, perm1_w[S-1:0]};

  perm_net #(.N(N), .MUL(P2_MUL), .ADD(P2_ADD)) u_perm2 (
    .d_i(inner_in),
    .d_o(perm2_w)
  );

  rsc_chain #(.N(N)) u_inner (
    .st_i  (inner_st),
    .bits_i(perm2_w),
    .par_o (inner_par),
    .st_o  (inner_nx)
  );

  for (genvar i = 0; i < K; i++) begin : g_punct
    assign punct[i] = inner_par[2*i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      outer_st    <= '0;
      inner_st    <= '0;
    end else begin
      if (in_fire) begin
        out_valid_q <= 1'b1;
        out_data_q  <= {punct, outer_par, in_data};
        outer_st    <= outer_nx;
        inner_st    <= inner_nx;
      end else if (out_fire) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

endmodule

// File: rtl/coupled_concat_encoder_chk.sv
module coupled_concat_encoder_chk #(
  parameter int K = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_fire,
  input logic [K-1:0]   in_data,
  input logic           out_valid,
  input logic           out_ready,
  input logic [3*K-1:0] out_data,
  input logic [1:0]     outer_st,
  input logic [1:0]     inner_st
);

  a_r1_rise_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_fire));

  a_r1_accept_gives_output: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r3_systematic: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (out_data[K-1:0] == $past(in_data)));

  // R4: first outer parity bit depends only on bit 0 and the s1 state bit
  a_r4_first_parity: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (out_data[K] == ($past(in_data[0]) ^ $past(outer_st[0]))));

  a_r9_state_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_fire |=> ($stable(outer_st) && $stable(inner_st)));

endmodule

bind coupled_concat_encoder coupled_concat_encoder_chk #(.K(K)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_fire  (in_fire),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .outer_st (outer_st),
  .inner_st (inner_st)
);

// File: tb/coupled_concat_encoder_tb_top.sv
module coupled_concat_encoder_tb_top;

  localparam int K   = 16;
  localparam int M   = 1;
  localparam int N   = 2 * K;
  localparam int S   = N / (M + 1);
  localparam int CW  = 3 * K;
  localparam int A1  = 5;
  localparam int B1  = 3;
  localparam int A2  = 7;
  localparam int B2  = 11;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [K-1:0]  in_data;
  logic          out_valid;
  logic          out_ready;
  logic [CW-1:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;

  coupled_concat_encoder #(
    .K(K), .M(M), .P1_MUL(A1), .P1_ADD(B1), .P2_MUL(A2), .P2_ADD(B2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input logic [CW-1:0] act,
                       input logic [CW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_os, m_is;                 // state as integer: bit1 = newest delay, bit0 = oldest
  logic [N-1:0] m_hist [1:M];     // full first-permuted words of past blocks

  task automatic m_reset();
    m_os = 0;
    m_is = 0;
    for (int d = 1; d <= M; d++) m_hist[d] = '0;
  endtask

  task automatic m_rsc(input int n, input logic [N-1:0] din, output logic [N-1:0] pout,
                       inout int st);
    pout = '0;
    for (int i = 0; i < n; i++) begin
      int r1, r2, w;
      r1 = (st >> 1) & 1;
      r2 = st & 1;
      w  = int'(din[i]) ^ r1 ^ r2;
      pout[i] = 1'(w ^ r2);
      st = (w << 1) | r1;
    end
  endtask

  task automatic m_step(input logic [K-1:0] u, output logic [CW-1:0] code);
    logic [N-1:0] opf, w, q, x, y, ip;
    m_rsc(K, {{K{1'b0}}, u}, opf, m_os);
    w = {opf[K-1:0], u};
    for (int i = 0; i < N; i++) q[i] = w[(A1 * i + B1) % N];
    x = '0;
    x[S-1:0] = q[S-1:0];
    for (int j = 1; j <= M; j++) x[j*S +: S] = m_hist[j][j*S +: S];
    for (int d = M; d >= 2; d--) m_hist[d] = m_hist[d-1];
    m_hist[1] = q;
    for (int i = 0; i < N; i++) y[i] = x[(A2 * i + B2) % N];
    m_rsc(N, y, ip, m_is);
    code = '0;
    code[K-1:0]   = u;
    code[2*K-1:K] = opf[K-1:0];
    for (int i = 0; i < K; i++) code[2*K+i] = ip[2*i];
  endtask

  task automatic check_fields(input logic [CW-1:0] exp);
    check(out_valid === 1'b1, "R1 out_valid after accept", {{(CW-1){1'b0}}, out_valid}, 1);
    check(out_data[K-1:0] === exp[K-1:0], "R3 systematic field", out_data, exp);
    check(out_data[2*K-1:K] === exp[2*K-1:K], "R4 R9 outer parity field", out_data, exp);
    check(out_data[CW-1:2*K] === exp[CW-1:2*K], "R5 R6 R7 R8 R9 inner field", out_data, exp);
  endtask

  task automatic send(input logic [K-1:0] d);
    logic [CW-1:0] exp;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    m_step(d, exp);
    check_fields(exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [K-1:0]  lfsr;
    logic [CW-1:0] exp_b, exp_c;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_data   = '0;
    out_ready = 1'b1;
    m_reset();
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10 no block held in reset", {{(CW-1){1'b0}}, out_valid}, 0);
    check(in_ready === 1'b1, "R1 ready in reset", {{(CW-1){1'b0}}, in_ready}, 1);
    rst_n = 1'b1;

    // R10: zero block after reset -> zero code
    send('0);
    check(out_data === '0, "R10 zero block after reset", out_data, '0);
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid falls after transfer", {{(CW-1){1'b0}}, out_valid}, 0);

    // Walking single bit: R4 R5 R6 R7 R8 over every position
    for (int k = 0; k < K; k++) send(K'(1) << k);
    send('1);
    send(16'hAAAA);
    send(16'h5555);
    send('0);

    // Pseudo-random chain: R9 carry over many back-to-back blocks
    lfsr = 16'hACE1;
    for (int n = 0; n < 24; n++) begin
      send(lfsr);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    // R2 stall: hold B while C waits
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = 16'h3C5A;
    @(negedge clk);
    m_step(16'h3C5A, exp_b);
    check_fields(exp_b);
    in_data = 16'hF00D;
    for (int c = 0; c < 3; c++) begin
      check(in_ready === 1'b0, "R2 in_ready low on stall", {{(CW-1){1'b0}}, in_ready}, 0);
      check(out_valid === 1'b1 && out_data === exp_b, "R2 held block stable", out_data, exp_b);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    m_step(16'hF00D, exp_c);
    check_fields(exp_c);   // R9: state unchanged during stall
    send(16'h0001);

    // R10 reset mid-stream clears states and owed slices
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0, "R10 mid-stream reset drops block", {{(CW-1){1'b0}}, out_valid}, 0);
    rst_n = 1'b1;
    m_reset();
    send('0);
    check(out_data === '0, "R10 owed slices cleared", out_data, '0);
    send(16'h8001);
    send(16'h1234);
    send(16'hFFFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule